// File: doc/BRIEF.md
# Endian-Aware Store Merge Engine

This block accepts one store request at a time and commits it to a single-port synchronous memory that is organised as 32-bit words. Each request carries a byte address, a 3-bit size code, a byte-order flag, a 256-bit data bus with a matching 32-bit byte-enable vector, and a 4-bit memory attribute field. The engine decodes the size code and rejects the two illegal values. Byte and halfword stores become a read-modify-write of one memory word. Word stores and larger stores become a run of whole-word writes, one per cycle. In big-endian mode the run is written in descending address order.

On the data bus, byte k is `st_data[8k+7:8k]`. The store data starts at the offset of the lowest asserted byte enable. Memory is read one cycle after the request for it: `mem_rdata` carries the word addressed in the previous cycle. When the last write of a store is done, the engine pulses a done signal. An illegal size code produces an error pulse and causes no memory traffic.

Top module: `store_merge_engine`

## Requirements
- R1: Size codes map to byte counts as follows: 1→1, 2→2, 4→4, 5→8, 6→16, 7→32. A store of 4 bytes or more writes count/4 whole words.
- R2: Size codes 0 and 3 are illegal. In the cycle after acceptance, `st_len_err` is high for one cycle, `mem_en` stays low and `st_done` stays low.
- R3: The start offset s is the index of the lowest set bit of `st_byte_en`, or 0 when no bit is set. For 16- and 32-byte stores, s is forced to 0. The base word address is bits [MEM_AW+1:2] of ({addr[31:4],4'b0} + s).
- R4: A byte store replaces lane addr[1:0] of the base word in little-endian mode, or lane 3−addr[1:0] in big-endian mode, with data byte s. Lane n is bits [8n+7:8n]. The other three bytes keep their old value.
- R5: A halfword store takes data bytes s and s+1 (as bits [15:0], byte s low) and uses h = addr[1] as the index. It writes memory bits [16h+15:16h] in little-endian mode, or bits [16(1−h)+15:16(1−h)] in big-endian mode. The other halfword is kept.
- R6: Word j of a store of 4 bytes or more is bits [31:0] of `st_data` shifted right by 8·(s+4j). A 4-byte store writes word 0 with no merge.
- R7: In a store of n words, little-endian mode writes word j to address base+j. Big-endian mode writes word j to base+n−1−j, so the first data word lands highest. Addresses wrap modulo 2^MEM_AW.
- R8: A byte or halfword store issues a read in the first cycle after acceptance and the write to the same address in the second. An n-word store writes in cycles 1..n after acceptance. `st_ready` stays low throughout.
- R9: `st_done` is a one-cycle pulse in the cycle after the last write, with `st_ready` high in that cycle.
- R10: `st_uncached` holds bit 2 of `st_attr` from the most recently accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Engine idle; the request is accepted when valid and ready are both high |
| st_addr | input | 32 | Byte address |
| st_len | input | 3 | Size code |
| st_big_end | input | 1 | 1 = big-endian lane and word order |
| st_data | input | 256 | Store data bus, byte k at [8k+7:8k] |
| st_byte_en | input | 32 | Byte enables; the lowest set bit gives the start offset |
| st_attr | input | 4 | Memory attribute; bit 2 = caching inhibited |
| st_done | output | 1 | One-cycle commit pulse |
| st_len_err | output | 1 | One-cycle illegal-size pulse |
| st_uncached | output | 1 | Inhibit attribute of the last accepted store |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MEM_AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The hardest case to reach is a big-endian multi-word store whose base sits near the top of the word space. Here the descending order and the modulo wrap meet, and a store start offset that is not word-aligned also shifts every word. Directed stores place 32-byte and 8-byte runs just below the wrap point in both byte orders, and every byte lane and halfword index is exercised in both modes. A long random stream then draws random addresses, start offsets (including offsets near the top of the bus), size codes (the illegal ones included) and attributes. After every store the whole memory is compared with a reference image.

// File: rtl/sme_pkg.sv
// Package: shared types and constants for the store merge engine.
// Assumes a 32-bit memory word; the size code caps stores at 32 bytes.
package sme_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 32;

    typedef enum logic [1:0] {
        SM_IDLE  = 2'd0,
        SM_READ  = 2'd1,
        SM_MERGE = 2'd2,
        SM_WRITE = 2'd3
    } sm_state_t;

    // Byte count for a size code; 0 marks an illegal code.
    function automatic logic [5:0] size_bytes(input logic [2:0] code);
        case (code)
            3'd1:    size_bytes = 6'd1;
            3'd2:    size_bytes = 6'd2;
            3'd4:    size_bytes = 6'd4;
            3'd5:    size_bytes = 6'd8;
            3'd6:    size_bytes = 6'd16;
            3'd7:    size_bytes = 6'd32;
            default: size_bytes = 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/sme_decode.sv
// Module: sme_decode
// Decodes the size code and byte enables of a request into legality,
// sub-word kind, word count, start offset and base word address.
// Assumes BUS_BYTES = 32 (the largest size code is 32 bytes).
module sme_decode
    import sme_pkg::*;
#(
    parameter int BUS_BYTES = 32,
    parameter int MEM_AW    = 10,
    parameter int CNT_W     = 4,
    parameter int SB_W      = $clog2(BUS_BYTES)
) (
    input  logic [2:0]           len_code,
    input  logic [BUS_BYTES-1:0] byte_en,
    input  logic [31:0]          addr,
    output logic                 legal,
    output logic                 sub_word,
    output logic                 is_half,
    output logic [CNT_W-1:0]     n_words,
    output logic [SB_W-1:0]      start_byte,
    output logic [MEM_AW-1:0]    base_word
);
    logic [5:0]  nbytes;
    logic [SB_W-1:0] first_en;
    logic [31:0] base_full;
    logic        unused_addr;

    // Size decode: byte count, kind and word count.
    always_comb begin
        nbytes   = size_bytes(len_code);
        legal    = (nbytes != 6'd0);
        sub_word = (nbytes == 6'd1) || (nbytes == 6'd2);
        is_half  = (nbytes == 6'd2);
        n_words  = sub_word ? CNT_W'(1) : CNT_W'(nbytes >> 2);
    end

    // Priority search for the lowest asserted byte enable.
    always_comb begin
        first_en = '0;
        for (int i = BUS_BYTES - 1; i >= 0; i--) begin
            if (byte_en[i]) first_en = SB_W'(i);
        end
    end

    // Start offset (zero for 16/32-byte stores) and aligned base word.
    always_comb begin
        start_byte = (nbytes >= 6'd16) ? '0 : first_en;
        base_full  = {addr[31:4], 4'b0000} + 32'(start_byte);
        base_word  = base_full[MEM_AW+1:2];
    end

    assign unused_addr = ^{addr[3:0], base_full};
endmodule

// File: rtl/sme_lane_merge.sv
// Module: sme_lane_merge
// Purely combinational merge of a byte or halfword into an old memory
// word, with the lane mirrored in big-endian mode.
// Assumes the new data sits in the low bits of new_bits.
module sme_lane_merge
    import sme_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_bits,
    input  logic [1:0]        addr_lo,
    input  logic              is_half,
    input  logic              big_end,
    output logic [WORD_W-1:0] merged
);
    logic [1:0] byte_lane;
    logic       half_idx;
    logic       unused_new;

    // Lane selection and insertion, keeping the untouched bytes.
    always_comb begin
        byte_lane = big_end ? ~addr_lo : addr_lo;
        half_idx  = big_end ? ~addr_lo[1] : addr_lo[1];
        merged    = old_word;
        if (is_half) merged[16*half_idx +: 16] = new_bits[15:0];
        else         merged[8*byte_lane +: 8]  = new_bits[7:0];
    end

    assign unused_new = ^new_bits[31:16];
endmodule

// File: rtl/sme_ctrl.sv
// Module: sme_ctrl
// Sequencer: accepts a decoded request, runs the read-modify-write or the
// multi-word write run, drives the memory port and raises done/error.
// Assumes the memory returns read data the cycle after a read.
module sme_ctrl
    import sme_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              legal,
    input  logic              sub_word,
    input  logic              big_end,
    input  logic [CNT_W-1:0]  n_words,
    input  logic [MEM_AW-1:0] base_word,
    output logic              ready,
    output logic              accept,
    output logic              mem_en,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              in_merge,
    output logic [CNT_W-1:0]  word_idx,
    output logic              done,
    output logic              len_err
);
    sm_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  r_nw;
    logic [MEM_AW-1:0] r_base;
    logic              r_big;

    assign ready    = (state == SM_IDLE);
    assign accept   = req_valid && ready;
    assign in_merge = (state == SM_MERGE);
    assign word_idx = cnt;

    // Memory port drive from the current state and word counter.
    always_comb begin
        mem_en   = (state != SM_IDLE);
        mem_we   = (state == SM_MERGE) || (state == SM_WRITE);
        mem_addr = r_base;
        if (state == SM_WRITE)
            mem_addr = r_big ? r_base + MEM_AW'(r_nw - CNT_W'(1) - cnt)
                             : r_base + MEM_AW'(cnt);
    end

    // State, counter and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SM_IDLE;
            cnt     <= '0;
            r_nw    <= '0;
            r_base  <= '0;
            r_big   <= 1'b0;
            done    <= 1'b0;
            len_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            len_err <= 1'b0;
            case (state)
                SM_IDLE: if (accept) begin
                    cnt    <= '0;
                    r_nw   <= n_words;
                    r_base <= base_word;
                    r_big  <= big_end;
                    if (!legal)        len_err <= 1'b1;
                    else if (sub_word) state   <= SM_READ;
                    else               state   <= SM_WRITE;
                end
                SM_READ:  state <= SM_MERGE;
                SM_MERGE: begin
                    state <= SM_IDLE;
                    done  <= 1'b1;
                end
                SM_WRITE: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == r_nw - CNT_W'(1)) begin
                        state <= SM_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SM_IDLE;
            endcase
        end
    end

    // R2: an illegal code yields an error pulse and no memory access.
    assert_illegal_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !legal) |=> (len_err && !mem_en && !done));
    // R9: done lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the engine is not ready while it drives memory.
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !ready);
    // R8: a read is followed by a write to the same word.
    assert_rmw_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we && $stable(mem_addr)));
    // R7: little-endian runs ascend by one word per cycle.
    assert_le_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SM_WRITE && $past(state) == SM_WRITE && !r_big)
        |-> mem_addr == $past(mem_addr) + MEM_AW'(1));
    // R7: big-endian runs descend by one word per cycle.
    assert_be_descend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SM_WRITE && $past(state) == SM_WRITE && r_big)
        |-> mem_addr == $past(mem_addr) - MEM_AW'(1));
endmodule

// File: rtl/store_merge_engine.sv
// Module: store_merge_engine (top)
// Commits one store at a time to a word memory: decodes the size, merges
// sub-word data by read-modify-write, writes multi-word runs in byte-order
// dependent address order, and pulses done or error.
// Assumes a single-port synchronous memory with one-cycle read latency.
module store_merge_engine
    import sme_pkg::*;
#(
    parameter int BUS_BYTES = 32,
    parameter int MEM_AW    = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [31:0]            st_addr,
    input  logic [2:0]             st_len,
    input  logic                   st_big_end,
    input  logic [8*BUS_BYTES-1:0] st_data,
    input  logic [BUS_BYTES-1:0]   st_byte_en,
    input  logic [3:0]             st_attr,
    output logic                   st_done,
    output logic                   st_len_err,
    output logic                   st_uncached,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [MEM_AW-1:0]      mem_addr,
    output logic [WORD_W-1:0]      mem_wdata,
    input  logic [WORD_W-1:0]      mem_rdata
);
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int MAX_WORDS = BUS_BYTES / WORD_BYTES;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int SB_W      = $clog2(BUS_BYTES);
    localparam int OFF_W     = SB_W + CNT_W + 3;

    logic              d_legal, d_sub, d_half;
    logic [CNT_W-1:0]  d_nw;
    logic [SB_W-1:0]   d_start;
    logic [MEM_AW-1:0] d_base;
    logic              accept, in_merge;
    logic [CNT_W-1:0]  word_idx;

    logic [BUS_W-1:0]  r_data;
    logic [SB_W-1:0]   r_start;
    logic [1:0]        r_addr_lo;
    logic              r_half, r_big;
    logic [OFF_W-1:0]  byte_off;
    logic [BUS_W-1:0]  shifted;
    logic [WORD_W-1:0] merged;
    logic              unused_attr;

    sme_decode #(.BUS_BYTES(BUS_BYTES), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .SB_W(SB_W)) dec_i (
        .len_code(st_len), .byte_en(st_byte_en), .addr(st_addr),
        .legal(d_legal), .sub_word(d_sub), .is_half(d_half),
        .n_words(d_nw), .start_byte(d_start), .base_word(d_base)
    );

    sme_ctrl #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(st_valid),
        .legal(d_legal), .sub_word(d_sub), .big_end(st_big_end),
        .n_words(d_nw), .base_word(d_base),
        .ready(st_ready), .accept(accept),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .in_merge(in_merge), .word_idx(word_idx),
        .done(st_done), .len_err(st_len_err)
    );

    // Capture the payload and lane controls of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_data      <= '0;
            r_start     <= '0;
            r_addr_lo   <= '0;
            r_half      <= 1'b0;
            r_big       <= 1'b0;
            st_uncached <= 1'b0;
        end else if (accept) begin
            r_data      <= st_data;
            r_start     <= d_start;
            r_addr_lo   <= st_addr[1:0];
            r_half      <= d_half;
            r_big       <= st_big_end;
            st_uncached <= st_attr[2];
        end
    end

    // Select the data word for the current write from the bus.
    always_comb begin
        byte_off = OFF_W'(r_start) + OFF_W'({word_idx, 2'b00});
        shifted  = r_data >> {byte_off, 3'b000};
    end

    sme_lane_merge merge_i (
        .old_word(mem_rdata), .new_bits(shifted[WORD_W-1:0]),
        .addr_lo(r_addr_lo), .is_half(r_half), .big_end(r_big),
        .merged(merged)
    );

    assign mem_wdata   = in_merge ? merged : shifted[WORD_W-1:0];
    assign unused_attr = ^{st_attr[3], st_attr[1:0]};

    // R9: done is raised together with ready.
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> st_ready);
    // R2: error and done never coincide.
    assert_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_done && st_len_err));
endmodule

// File: tb/store_merge_engine_tb_top.sv
`timescale 1ns/1ps
module store_merge_engine_tb_top;
    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [2:0]   st_len = '0;
    logic         st_big_end = 1'b0;
    logic [255:0] st_data = '0;
    logic [31:0]  st_byte_en = '0;
    logic [3:0]   st_attr = '0;
    logic         st_done, st_len_err, st_uncached;
    logic         mem_en, mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata = '0;

    logic [31:0] mem  [DEPTH];
    logic [31:0] refm [DEPTH];
    int total = 0;
    int bad = 0;
    int en_cnt = 0;

    always #2.5 clk = ~clk;

    store_merge_engine #(.BUS_BYTES(32), .MEM_AW(MEM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_len(st_len), .st_big_end(st_big_end),
        .st_data(st_data), .st_byte_en(st_byte_en), .st_attr(st_attr),
        .st_done(st_done), .st_len_err(st_len_err), .st_uncached(st_uncached),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model with one-cycle read latency, plus an access counter.
    always @(posedge clk) begin
        if (mem_en) begin
            en_cnt <= en_cnt + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int size_of(input logic [2:0] c);
        case (c)
            3'd1: return 1;  3'd2: return 2;  3'd4: return 4;
            3'd5: return 8;  3'd6: return 16; 3'd7: return 32;
            default: return 0;
        endcase
    endfunction

    // Reference update following R1, R3..R7.
    task automatic ref_apply(input logic [31:0] a, input logic [2:0] c, input bit big,
                             input logic [255:0] d, input logic [31:0] be);
        int nb, s, base, n;
        logic [255:0] sh;
        logic [31:0] w;
        nb = size_of(c);
        s = 0;
        for (int i = 31; i >= 0; i--) if (be[i]) s = i;
        if (nb >= 16) s = 0;
        base = int'((((a & 32'hFFFF_FFF0) + s) >> 2)) % DEPTH;
        if (nb == 1 || nb == 2) begin
            sh = d >> (8 * s);
            w = refm[base];
            if (nb == 1) begin
                int lane;
                lane = big ? 3 - int'(a[1:0]) : int'(a[1:0]);
                w[8*lane +: 8] = sh[7:0];
            end else begin
                int h;
                h = big ? 1 - int'(a[1]) : int'(a[1]);
                w[16*h +: 16] = sh[15:0];
            end
            refm[base] = w;
        end else begin
            n = nb / 4;
            for (int j = 0; j < n; j++) begin
                sh = d >> (8 * (s + 4 * j));
                refm[big ? (base + n - 1 - j) % DEPTH : (base + j) % DEPTH] = sh[31:0];
            end
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [2:0] c, input bit big,
                            input logic [255:0] d, input logic [31:0] be,
                            input logic [3:0] at);
        int nb, expk, k, early_ready, mism;
        nb = size_of(c);
        @(negedge clk);
        en_cnt = 0;
        st_valid = 1'b1; st_addr = a; st_len = c; st_big_end = big;
        st_data = d; st_byte_en = be; st_attr = at;
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        check(st_uncached == at[2], "R10", "uncached flag", st_uncached, at[2]);
        if (nb == 0) begin
            check(st_len_err && !st_done, "R2", "error pulse", {st_len_err, st_done}, 2'b10);
            @(negedge clk);
            check(!st_len_err, "R2", "error width", st_len_err, 0);
            @(negedge clk);
            check(en_cnt == 0 && !st_done, "R2", "memory accesses", en_cnt, 0);
        end else begin
            expk = (nb <= 2) ? 3 : nb / 4 + 1;
            k = 1; early_ready = 0;
            while (!st_done && k < 40) begin
                if (st_ready) early_ready++;
                @(negedge clk);
                k++;
            end
            check(k == expk, (nb <= 2) ? "R8" : "R1", "done cycle", k, expk);
            check(early_ready == 0 && st_ready, "R8", "ready low while busy", early_ready, 0);
            check(en_cnt == ((nb <= 2) ? 2 : nb / 4), "R8", "access count", en_cnt,
                  (nb <= 2) ? 2 : nb / 4);
            @(negedge clk);
            check(!st_done, "R9", "done width", st_done, 0);
            ref_apply(a, c, big, d, be);
        end
        mism = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mem[i] !== refm[i]) begin
                if (mism == 0)
                    check(0, (nb == 1) ? "R4" : (nb == 2) ? "R5" : (nb == 4) ? "R6" : "R7",
                          $sformatf("mem[%0d]", i), mem[i], refm[i]);
                mism++;
            end
        end
        if (mism == 0) check(1, "R3", "memory image", 0, 0);
    endtask

    function automatic logic [255:0] rnd_data();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [255:0] pat;
        void'($urandom(32'd1357));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = $urandom;
            refm[i] = mem[i];
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(st_ready && !st_done && !st_len_err && !mem_en, "R8", "reset state",
              {st_ready, st_done, st_len_err, mem_en}, 4'b1000);

        pat = 256'h1F1E1D1C_1B1A1918_17161514_13121110_0F0E0D0C_0B0A0908_07060504_03020100;
        // R4: every byte lane, both orders.
        for (int b = 0; b < 2; b++)
            for (int l = 0; l < 4; l++)
                do_store(32'h100 + l, 3'd1, b[0], pat, 32'h0000_0020, 4'h0);
        // R5: both halfword indexes, both orders.
        for (int b = 0; b < 2; b++)
            for (int h = 0; h < 2; h++)
                do_store(32'h200 + 2 * h, 3'd2, b[0], pat, 32'h0000_0400, 4'h4);
        // R6: word store with unaligned start offset.
        do_store(32'h300, 3'd4, 1'b0, pat, 32'h0000_0008, 4'h0);
        // R7: multi-word stores in both orders, including the wrap point.
        for (int b = 0; b < 2; b++) begin
            do_store(32'h400, 3'd5, b[0], pat, 32'h0000_0010, 4'h0);
            do_store(32'h500, 3'd6, b[0], pat, 32'hFFFF_0000, 4'h0);
            do_store(32'h600, 3'd7, b[0], pat, 32'h0000_0001, 4'h0);
            do_store(32'hFF0, 3'd7, b[0], pat, 32'h0, 4'h4);
            do_store(32'hFF8, 3'd5, b[0], pat, 32'h0000_0004, 4'h0);
        end
        // R2: both illegal codes.
        do_store(32'h700, 3'd0, 1'b0, pat, 32'h1, 4'h0);
        do_store(32'h700, 3'd3, 1'b1, pat, 32'h1, 4'h4);
        // Random stream, illegal codes included.
        for (int t = 0; t < 400; t++) begin
            int s;
            logic [31:0] be;
            s = $urandom_range(0, 31);
            be = ($urandom & ~((32'h1 << s) - 1)) | (32'h1 << s);
            if ($urandom_range(0, 15) == 0) be = 32'h0;
            do_store($urandom, 3'($urandom_range(0, 7)), 1'($urandom),
                     rnd_data(), be, 4'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule